// File: doc/BRIEF.md
# Non-Volatile Setting Store Controller

This controller holds the 7-bit code that drives a current-setting DAC, together with a modelled non-volatile copy of that code. The non-volatile copy is a storage register that keeps its content through reset. At reset the controller reloads the DAC code from it, so the last programmed setting comes back on every start-up.

A serial-interface front end, which is not part of this block, turns bus traffic into one-cycle request pulses. A register-write request changes only the DAC code. A store request changes the DAC code and also starts a timed programming cycle; at the end of that cycle the new code is written into the non-volatile copy. An unlock input permits or refuses store requests. While the unlock input is low, a store request is handled as a register-only write. The same unlock input produces two outputs: an inverted copy of itself, and an enable that closes the switch connecting an alternate clock pin onto the serial clock. While a programming cycle runs, a busy flag is raised for the bus to read, and every write request is ignored.

Top module: `nvs_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `dac_code` equals the non-volatile value, `busy` is 0, and `nv_value` keeps the value it had before reset.
- R2: A `wr_reg` pulse taken while `busy` is 0 loads `wr_data` into `dac_code` one clock later, whatever the state of `nv_unlock`.
- R3: A `wr_nv` pulse taken while `nv_unlock` is 0 loads `dac_code` only. `busy` stays 0 and `nv_value` does not change.
- R4: A `wr_nv` pulse taken while `nv_unlock` is 1 and `busy` is 0 loads `dac_code` one clock later and raises `busy` on the same clock edge. `nv_value` takes the new code on the edge where `busy` falls.
- R5: After an accepted store request, `busy` stays high for exactly `PROG_CYCLES` clock cycles.
- R6: While `busy` is 1, both request inputs are ignored. `dac_code` does not change, and the value being programmed is committed unchanged.
- R7: When `wr_reg` and `wr_nv` arrive in the same cycle, the store request wins. With `nv_unlock` at 1 a programming cycle starts.
- R8: `lock_flag` is the inverse of `nv_unlock` at all times, with no clock delay.
- R9: `alt_clk_en` equals `nv_unlock` at all times, with no clock delay. A value of 1 closes the alternate-clock switch.
- R10: A reset during a programming cycle aborts it. `busy` falls, `nv_value` keeps its old value, and no commit happens later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; triggers the restore from the non-volatile copy |
| nv_unlock | input | 1 | 1 permits store requests; 0 (the pulled-down default) protects the copy |
| wr_reg | input | 1 | One-cycle pulse: write `wr_data` to the DAC code only |
| wr_nv | input | 1 | One-cycle pulse: write `wr_data` to the DAC code and program it into the copy |
| wr_data | input | W | New setting code |
| dac_code | output | W | Registered code that drives the DAC |
| nv_value | output | W | Current content of the non-volatile copy |
| busy | output | 1 | High while a programming cycle runs |
| lock_flag | output | 1 | Inverse of `nv_unlock` |
| alt_clk_en | output | 1 | Enable for the switch that connects the alternate clock pin to the serial clock |

## Verification
`dac_code` and the rising edge of `busy` are due one clock edge after the request. `nv_value` changes, and `busy` falls, exactly `PROG_CYCLES` edges after the accepting edge. The two protect-derived outputs follow `nv_unlock` within the same cycle. The bench drives inputs on falling edges and samples on the next falling edge, so every registered result is read half a cycle after the edge that produced it. The programming window is counted sample by sample: the last busy sample and the first idle sample are both checked.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [1:0] {
    REQ_NONE = 2'd0,
    REQ_REG  = 2'd1,
    REQ_NV   = 2'd2
  } req_kind_e;
endpackage

// File: rtl/nvs_req_arb.sv
module nvs_req_arb
  import nvs_pkg::*;
(
  input  logic      wr_reg,
  input  logic      wr_nv,
  input  logic      nv_unlock,
  input  logic      busy,
  output req_kind_e kind
);
  // Store requests win over register writes; protection degrades them to register writes.
  always_comb begin
    if (busy)                    kind = REQ_NONE;
    else if (wr_nv && nv_unlock) kind = REQ_NV;
    else if (wr_nv || wr_reg)    kind = REQ_REG;
    else                         kind = REQ_NONE;
  end
endmodule

// File: rtl/nvs_prog_timer.sv
module nvs_prog_timer #(
  parameter int PROG_CYCLES = 15_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PROG_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (done) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  // R6
  start_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy_q);

  // R5
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy_q);

  // R5
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (cnt_q <= LAST));
endmodule

// File: rtl/nvs_cell.sv
module nvs_cell #(
  parameter int          W       = 7,
  parameter logic [W-1:0] NV_INIT = '0
) (
  input  logic         clk,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  // Deliberately not reset: models retained content.
  logic [W-1:0] mem_q = NV_INIT;

  always_ff @(posedge clk) begin
    if (load) mem_q <= din;
  end

  assign dout = mem_q;
endmodule

// File: rtl/nvs_ctrl.sv
module nvs_ctrl
  import nvs_pkg::*;
#(
  parameter int           W           = 7,
  parameter int           PROG_CYCLES = 15_000_000,
  parameter logic [W-1:0] NV_INIT     = W'(64)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         nv_unlock,
  input  logic         wr_reg,
  input  logic         wr_nv,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] dac_code,
  output logic [W-1:0] nv_value,
  output logic         busy,
  output logic         lock_flag,
  output logic         alt_clk_en
);
  req_kind_e    kind;
  logic         done;
  logic [W-1:0] dac_q;
  logic [W-1:0] pend_q;
  logic [W-1:0] cell_q;

  nvs_req_arb u_arb (
    .wr_reg    (wr_reg),
    .wr_nv     (wr_nv),
    .nv_unlock (nv_unlock),
    .busy      (busy),
    .kind      (kind)
  );

  nvs_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (kind == REQ_NV),
    .busy  (busy),
    .done  (done)
  );

  nvs_cell #(.W(W), .NV_INIT(NV_INIT)) u_cell (
    .clk  (clk),
    .load (done && !rst),
    .din  (pend_q),
    .dout (cell_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dac_q  <= cell_q;
      pend_q <= cell_q;
    end else begin
      unique case (kind)
        REQ_REG: dac_q <= wr_data;
        REQ_NV: begin
          dac_q  <= wr_data;
          pend_q <= wr_data;
        end
        default: ;
      endcase
    end
  end

  assign dac_code   = dac_q;
  assign nv_value   = cell_q;
  assign lock_flag  = !nv_unlock;
  assign alt_clk_en = nv_unlock;

  // R4
  accept_raises_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_nv && nv_unlock && !busy) |=> busy);

  // R3
  protect_no_prog_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !nv_unlock) |=> !busy);

  // R6
  busy_dac_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(dac_code));

  // R2
  idle_dac_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_reg && !wr_nv) |=> $stable(dac_code));

  // R4
  nv_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(nv_value));
endmodule

// File: tb/sim_nvs_ctrl.sv
module sim_nvs_ctrl;
  localparam int          W    = 7;
  localparam int          PROG = 12;
  localparam logic [6:0]  INIT = 7'h2A;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       nv_unlock = 1'b0;
  logic       wr_reg = 1'b0;
  logic       wr_nv = 1'b0;
  logic [6:0] wr_data = '0;
  logic [6:0] dac_code, nv_value;
  logic       busy, lock_flag, alt_clk_en;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  nvs_ctrl #(.W(W), .PROG_CYCLES(PROG), .NV_INIT(INIT)) u0 (
    .clk(clk), .rst(rst), .nv_unlock(nv_unlock), .wr_reg(wr_reg), .wr_nv(wr_nv),
    .wr_data(wr_data), .dac_code(dac_code), .nv_value(nv_value), .busy(busy),
    .lock_flag(lock_flag), .alt_clk_en(alt_clk_en)
  );

  // {wr_reg, wr_nv, nv_unlock, data[6:0], expected dac[6:0]}
  localparam logic [16:0] VEC [5] = '{
    {1'b1, 1'b0, 1'b0, 7'h15, 7'h15},
    {1'b1, 1'b0, 1'b1, 7'h7F, 7'h7F},
    {1'b0, 1'b1, 1'b0, 7'h22, 7'h22},
    {1'b1, 1'b0, 1'b0, 7'h00, 7'h00},
    {1'b1, 1'b1, 1'b0, 7'h33, 7'h33}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic r, input logic n, input logic u, input logic [6:0] d);
    @(negedge clk);
    wr_reg = r; wr_nv = n; nv_unlock = u; wr_data = d;
    @(negedge clk);
    wr_reg = 1'b0; wr_nv = 1'b0;
  endtask

  task automatic pulse_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset dac", dac_code, INIT);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset nv", nv_value, INIT);
    chk("R8 lock low unlock", lock_flag, 1);
    chk("R9 switch open", alt_clk_en, 0);
    nv_unlock = 1'b1; #1;
    chk("R8 lock follows", lock_flag, 0);
    chk("R9 switch closed", alt_clk_en, 1);

    foreach (VEC[i]) begin
      do_op(VEC[i][16], VEC[i][15], VEC[i][14], VEC[i][13:7]);
      chk("R2/R3/R7 table dac", dac_code, VEC[i][6:0]);
      chk("R3 table busy", busy, 0);
      chk("R3 table nv", nv_value, INIT);
    end

    // R4 R5 R7: both requests, unlocked
    do_op(1'b1, 1'b1, 1'b1, 7'h5C);
    chk("R4 busy rise", busy, 1);
    chk("R4 dac", dac_code, 7'h5C);
    chk("R7 nv wins", nv_value, INIT);
    for (int k = 1; k < PROG; k++) @(negedge clk);
    chk("R5 last busy", busy, 1);
    chk("R4 nv before commit", nv_value, INIT);
    @(negedge clk);
    chk("R5 busy fall", busy, 0);
    chk("R4 nv commit", nv_value, 7'h5C);

    // R6: requests during programming ignored
    do_op(1'b0, 1'b1, 1'b1, 7'h11);
    do_op(1'b1, 1'b0, 1'b1, 7'h01);
    chk("R6 reg ignored", dac_code, 7'h11);
    do_op(1'b0, 1'b1, 1'b1, 7'h02);
    chk("R6 nv ignored", dac_code, 7'h11);
    for (int k = 0; k < 2 * PROG && busy; k++) @(negedge clk);
    chk("R6 busy done", busy, 0);
    chk("R6 committed value", nv_value, 7'h11);

    // R1: restore after change
    do_op(1'b1, 1'b0, 1'b0, 7'h10);
    chk("R2 reg write", dac_code, 7'h10);
    pulse_reset();
    chk("R1 restore", dac_code, 7'h11);

    // R10: reset aborts programming
    do_op(1'b0, 1'b1, 1'b1, 7'h6E);
    repeat (3) @(negedge clk);
    pulse_reset();
    chk("R10 busy abort", busy, 0);
    chk("R10 nv kept", nv_value, 7'h11);
    chk("R10 dac restore", dac_code, 7'h11);
    repeat (PROG + 2) @(negedge clk);
    chk("R10 no late commit", nv_value, 7'h11);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule